// File: doc/BRIEF.md
# Vertex Attribute Staging Buffer

This block keeps the current value of every vertex input attribute (sixteen slots, each a vector of four 32-bit components) as a command front end writes them. Values stay in place from one vertex to the next, so the front end only sends the attributes that change. Writing the position slot (slot 0) completes a vertex. The block then copies that vertex into the next of several input buffers that feed a shader core. It picks the buffers in turn, in round-robin order.

For each input buffer the block tracks which slots have changed since that buffer was last filled. A fill therefore copies only those slots, one per clock, through a single drain port tagged with the target buffer. The front end may keep writing while a fill runs. If a write hits a slot that the running fill has not yet copied, the old contents of that slot go out on the drain port in the same cycle, ahead of the normal order. The new value then waits for later fills, and the drain port never idles while work is pending. Each buffer has a valid/ready pair toward the core: valid means the buffer holds a complete vertex, and the ready handshake hands the buffer back.

Top module: `vattr_buffer`

## Requirements
- R1: After reset every slot holds (0.0, 0.0, 0.0, 1.0), i.e. components 0..2 are zero and component 3 is 32'h3F80_0000. Every slot counts as changed for every buffer. No buffer is in use, `dr_valid` and `ib_valid` are low, and the next fill targets buffer 0.
- R2: An accepted write sets the slot to the default vector, then replaces component c (bits 32c+31:32c) with the matching `wr_data` bits wherever `wr_mask[c]` is 1.
- R3: A slot keeps its value across any number of vertices until it is written again, and fills copy that kept value.
- R4: An accepted write to slot 0 starts a fill in the next cycle. Successive fills target buffers 0, 1, ..., NBUF-1, 0, ... and `dr_buf` names the target while `dr_valid` is high.
- R5: A fill copies exactly the slots written since the target buffer's previous fill, slot 0 included. It sends one slot per clock in ascending index order, and `dr_data` is the slot's value as it stood when slot 0 was written.
- R6: While a fill runs, an accepted write to a slot not yet copied by that fill makes `dr_slot` equal that slot in the same cycle. `dr_data` carries the slot's old value. The new value counts as changed for every buffer.
- R7: `ib_valid[b]` rises in the cycle after the last slot of buffer b's fill. It stays high until a cycle with `ib_ready[b]` high, which frees the buffer.
- R8: `wr_ready` is low for a slot-0 write while a fill runs or while the next target buffer is still in use. Writes to other slots are always accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Attribute write request |
| wr_ready | output | 1 | Write accepted this cycle |
| wr_slot | input | 4 | Attribute slot index; 0 is position |
| wr_mask | input | 4 | Per-component valid mask |
| wr_data | input | 128 | Four 32-bit components, component 0 in the low bits |
| dr_valid | output | 1 | Drain port carries a slot this cycle |
| dr_buf | output | 2 | Input buffer being filled |
| dr_slot | output | 4 | Slot index being copied |
| dr_data | output | 128 | Slot contents being copied |
| ib_valid | output | 3 | Per buffer: holds a complete vertex |
| ib_ready | input | 3 | Per buffer: core takes and frees the buffer |

## Verification
The bench builds the block with its defaults: sixteen slots and three input buffers. With three buffers, directed traffic soon wraps the round-robin order and fills every buffer, so it reaches the stall of a slot-0 write on a busy target and a second fill that copies only a few changed slots. A long stretch of random writes and random releases then drives writes into slots still waiting in a running fill. A behavioural model compares each output in every cycle.

// File: rtl/vattr_buffer.sv
module vattr_buffer #(
  parameter int NSLOT = 16,
  parameter int NBUF  = 3,
  parameter int CW    = 32,
  localparam int SW = $clog2(NSLOT),
  localparam int BW = (NBUF > 1) ? $clog2(NBUF) : 1,
  localparam int VW = 4 * CW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_valid,
  output logic            wr_ready,
  input  logic [SW-1:0]   wr_slot,
  input  logic [3:0]      wr_mask,
  input  logic [VW-1:0]   wr_data,
  output logic            dr_valid,
  output logic [BW-1:0]   dr_buf,
  output logic [SW-1:0]   dr_slot,
  output logic [VW-1:0]   dr_data,
  output logic [NBUF-1:0] ib_valid,
  input  logic [NBUF-1:0] ib_ready
);

  localparam logic [CW-1:0] ONE  = CW'(32'h3F80_0000);
  localparam logic [VW-1:0] DEFV = {ONE, {(3*CW){1'b0}}};

  logic [VW-1:0]    attr  [NSLOT];
  logic [NSLOT-1:0] dirty [NBUF];
  logic [NSLOT-1:0] pend;
  logic [NBUF-1:0]  busy;
  logic [BW-1:0]    cur, nxt, nxt_inc;
  logic [SW-1:0]    low;
  logic [VW-1:0]    wnew;
  logic             draining, is_pos, wr_acc, trig, preempt;

  assign draining = |pend;
  assign is_pos   = (wr_slot == '0);
  assign wr_ready = !is_pos || (!draining && !busy[nxt]);
  assign wr_acc   = wr_valid && wr_ready;
  assign trig     = wr_acc && is_pos;
  assign preempt  = wr_acc && pend[wr_slot];
  assign nxt_inc  = (nxt == BW'(NBUF-1)) ? '0 : nxt + 1'b1;

  always_comb begin
    low = '0;
    for (int i = NSLOT-1; i >= 0; i--)
      if (pend[i]) low = SW'(i);
  end

  always_comb begin
    wnew = DEFV;
    for (int c = 0; c < 4; c++)
      if (wr_mask[c]) wnew[c*CW +: CW] = wr_data[c*CW +: CW];
  end

  assign dr_valid = draining;
  assign dr_slot  = preempt ? wr_slot : low;
  assign dr_data  = attr[dr_slot];
  assign dr_buf   = cur;

  for (genvar b = 0; b < NBUF; b++) begin : g_ib
    assign ib_valid[b] = busy[b] && !(draining && cur == BW'(b));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSLOT; i++) attr[i] <= DEFV;
      for (int b = 0; b < NBUF; b++) dirty[b] <= '1;
      pend <= '0;
      busy <= '0;
      cur  <= '0;
      nxt  <= '0;
    end else begin
      if (draining) pend[dr_slot] <= 1'b0;
      for (int b = 0; b < NBUF; b++)
        if (ib_valid[b] && ib_ready[b]) busy[b] <= 1'b0;
      if (wr_acc) begin
        attr[wr_slot] <= wnew;
        for (int b = 0; b < NBUF; b++) dirty[b][wr_slot] <= 1'b1;
      end
      if (trig) begin
        pend       <= dirty[nxt] | NSLOT'(1);
        dirty[nxt] <= '0;
        busy[nxt]  <= 1'b1;
        cur        <= nxt;
        nxt        <= nxt_inc;
      end
    end
  end

  a_r2_empty_mask_default: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && wr_mask == 4'b0) |=> attr[$past(wr_slot)] == DEFV);

  a_r4_trigger_starts_fill: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> (dr_valid && dr_buf == $past(nxt)));

  a_r5_slot_sent_once: assert property (@(posedge clk) disable iff (!rst_n)
    dr_valid |=> !pend[$past(dr_slot)]);

  a_r7_valid_after_fill: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dr_valid) |-> ib_valid[$past(dr_buf)]);

  a_r8_pos_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_slot == '0 && dr_valid) |-> !wr_ready);

endmodule

// File: tb/vattr_buffer_bench.sv
module vattr_buffer_bench;
  localparam int NS = 16;
  localparam int NB = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_valid = 1'b0;
  logic          wr_ready;
  logic [3:0]    wr_slot = '0;
  logic [3:0]    wr_mask = '0;
  logic [127:0]  wr_data = '0;
  logic          dr_valid;
  logic [1:0]    dr_buf;
  logic [3:0]    dr_slot;
  logic [127:0]  dr_data;
  logic [NB-1:0] ib_valid;
  logic [NB-1:0] ib_ready = '0;

  always #4 clk = ~clk;

  vattr_buffer u_vattr_buffer (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_slot(wr_slot), .wr_mask(wr_mask), .wr_data(wr_data),
    .dr_valid(dr_valid), .dr_buf(dr_buf), .dr_slot(dr_slot), .dr_data(dr_data),
    .ib_valid(ib_valid), .ib_ready(ib_ready));

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  logic [127:0] m_attr [NS];
  logic [NS-1:0] m_dirty [NB];
  logic [NS-1:0] m_pend;
  bit   m_busy [NB];
  int   m_cur = 0, m_nxt = 0;
  bit   last_acc;

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
    end
  endtask

  function automatic logic [127:0] merged(logic [3:0] m, logic [127:0] d);
    logic [127:0] v;
    for (int c = 0; c < 4; c++)
      v[c*32 +: 32] = m[c] ? d[c*32 +: 32] : (c == 3 ? 32'h3F80_0000 : 32'h0);
    return v;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < NS; i++) m_attr[i] = merged(4'b0, '0);
    for (int b = 0; b < NB; b++) begin m_dirty[b] = '1; m_busy[b] = 0; end
    m_pend = '0; m_cur = 0; m_nxt = 0;
  endtask

  // one clock: compare at the falling edge, then advance the model
  task automatic step();
    bit any, ready, acc, pre;
    int low, slot;
    logic [NB-1:0] ibv;
    @(negedge clk);
    any = (m_pend != 0);
    ready = (wr_slot != 0) || (!any && !m_busy[m_nxt]);
    acc = wr_valid && ready;
    pre = acc && m_pend[wr_slot];
    low = 0;
    for (int i = NS-1; i >= 0; i--) if (m_pend[i]) low = i;
    slot = pre ? int'(wr_slot) : low;
    for (int b = 0; b < NB; b++) ibv[b] = m_busy[b] && !(any && m_cur == b);
    chk("R8 wr_ready", 128'(wr_ready), 128'(ready));
    chk("R4 dr_valid", 128'(dr_valid), 128'(any));
    if (any) begin
      chk(pre ? "R6 dr_slot" : "R5 dr_slot", 128'(dr_slot), 128'(slot));
      chk("R2 R3 dr_data", dr_data, m_attr[slot]);
      chk("R4 dr_buf", 128'(dr_buf), 128'(m_cur));
    end
    chk("R7 ib_valid", 128'(ib_valid), 128'(ibv));
    if (any) m_pend[slot] = 1'b0;
    for (int b = 0; b < NB; b++) if (ibv[b] && ib_ready[b]) m_busy[b] = 0;
    if (acc) begin
      m_attr[wr_slot] = merged(wr_mask, wr_data);
      for (int b = 0; b < NB; b++) m_dirty[b][wr_slot] = 1'b1;
      if (wr_slot == 0) begin
        m_pend = m_dirty[m_nxt];
        m_dirty[m_nxt] = '0;
        m_busy[m_nxt] = 1;
        m_cur = m_nxt;
        m_nxt = (m_nxt + 1) % NB;
      end
    end
    last_acc = acc;
    @(posedge clk); #1;
  endtask

  task automatic wr(int s, logic [3:0] m, logic [127:0] d);
    wr_valid = 1'b1; wr_slot = 4'(s); wr_mask = m; wr_data = d;
    do step(); while (!last_acc);
    wr_valid = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: reset state seen at the ports
    @(negedge clk);
    chk("R1 dr_valid", 128'(dr_valid), 128'(0));
    chk("R1 ib_valid", 128'(ib_valid), 128'(0));
    chk("R1 wr_ready", 128'(wr_ready), 128'(1));
    @(posedge clk); #1;
    // R1 R5: first fill of buffer 0 copies all sixteen slots, defaults included
    wr(3, 4'b0101, {32'hA3, 32'hA2, 32'hA1, 32'hA0});
    wr(0, 4'b1111, {32'h4, 32'h3, 32'h2, 32'h1});
    idle(18);
    // R2: empty mask leaves the default; R4: next target is buffer 1
    wr(5, 4'b0000, {4{32'hFFFF_FFFF}});
    wr(0, 4'b0011, {32'h0, 32'h0, 32'h22, 32'h11});
    idle(18);
    wr(0, 4'b1000, {32'h7, 96'h0});
    idle(18);
    // R8: all buffers in use, slot-0 write stalls until buffer 0 is freed
    wr_valid = 1'b1; wr_slot = 4'd0; wr_mask = 4'b1111; wr_data = {4{32'h55}};
    idle(4);
    ib_ready = 3'b001;
    step();
    ib_ready = 3'b000;
    do step(); while (!last_acc);
    wr_valid = 1'b0;
    idle(6);
    // R3 R7: release all, fill buffer 1 with only changed slots
    ib_ready = 3'b111; idle(2); ib_ready = 3'b000;
    wr(2, 4'b1111, {4{32'h12}});
    wr(4, 4'b0010, {4{32'h14}});
    wr(9, 4'b1100, {4{32'h19}});
    wr(0, 4'b0001, {4{32'h10}});
    // R6: write to a pending slot during the fill, then R8 stall on slot 0
    wr(9, 4'b1111, {4{32'h99}});
    wr(0, 4'b1111, {4{32'h20}});
    idle(20);
    // random traffic
    for (int n = 0; n < 3000; n++) begin
      wr_valid = $urandom_range(0, 2) != 0;
      wr_slot  = ($urandom_range(0, 3) == 0) ? 4'd0 : 4'($urandom_range(0, 15));
      wr_mask  = 4'($urandom_range(0, 15));
      wr_data  = {$urandom, $urandom, $urandom, $urandom};
      ib_ready = 3'($urandom_range(0, 7)) & 3'($urandom_range(0, 7));
      step();
    end
    wr_valid = 1'b0; ib_ready = '1;
    idle(20);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule